// File: doc/BRIEF.md
# Command/Response Register Mailbox Engine

This block is the device-side end of a host mailbox built from a handful of shared registers: one command/response word, three argument words, a signature word and a single-owner lock. The host takes the lock, fills the argument words, writes a command word with bit 31 set, waits for the engine to replace it with a response word (bit 31 clear), writes zero to clear it and then gives the lock back. All access goes through one synchronous register port that takes one read or write per cycle.

The engine checks the signature word before it acts on a command. It answers capability exchange and the five limit queries from its own parameters and configuration inputs. Context, statistics and unknown commands get a fail response, and a failure code goes into the first argument word. A watchdog counter flags a command/response word that stays non-zero for too long, which happens when a driver dies while it holds the lock. The engine then clears the word itself and frees the lock.

Top module: `cmd_mailbox`

## Requirements
- R1: After reset the command/response word, the three argument words and the signature word read 0, the lock is free and `stuckError` is 0.
- R2: A read of the lock word (address 5) returns 1 and takes the lock when it is free, and returns 0 while it is held. Any write to address 5 frees the lock.
- R3: A write to the command/response word (address 0) while the lock is not held is ignored.
- R4: The signature word (address 4) is read/write. It is valid when bits [31:16] equal 0xCAFE and bits [7:0], the function number, are below 8; bits [15:8] carry a version the engine ignores. A command issued under an invalid signature is answered FAIL (2), and argument 1 gets failure code 1.
- R5: A command write at clock edge k is replaced at edge k+1 by a response word with bit 31 clear: OK = 1, FAIL = 2.
- R6: Command codes 2 through 6 (bits [30:0]) answer OK and place, in argument 1, the max RDS rings, max SDS rings, max rules per context, max Rx contexts and max Tx contexts configuration input, in that order.
- R7: Command code 1 (capability exchange) answers OK with argument 1 = host argument 1 AND 0x73 and argument 2 = host argument 2 AND 0x03. The 0x73 vector is legacy context, multi-context, cut-through, large receive offload and large send offload at bits 0, 1, 4, 5 and 6. The 0x03 vector is basic NIC and network boot at bits 0 and 1.
- R8: Argument words are captured on the command write. A host write to argument 2 at the response edge is overridden by the capability result.
- R9: Codes 0, 7–10 and 14–16 (context and statistics commands) answer FAIL with failure code 2. Codes 11–13 and any code of 17 or above answer FAIL with failure code 3.
- R10: Writing 0 to the command/response word while holding the lock clears it. A command write while a command or response is pending is ignored, and so is a non-zero write with bit 31 clear.
- R11: When the command/response word has been non-zero for `STUCK_LIMIT` consecutive cycles, the engine clears it, frees the lock and sets `stuckError`. `stuckError` stays set until the next successful lock read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (the lock read has a side effect) |
| regAddr | input | 3 | Register select: 0 cmd/rsp, 1–3 args, 4 signature, 5 lock |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for the selected register, combinational |
| cfgMaxRdsRings | input | 32 | Value returned by code 2 |
| cfgMaxSdsRings | input | 32 | Value returned by code 3 |
| cfgMaxRules | input | 32 | Value returned by code 4 |
| cfgMaxRxCtx | input | 32 | Value returned by code 5 |
| cfgMaxTxCtx | input | 32 | Value returned by code 6 |
| stuckError | output | 1 | Set when a non-clear command/response word timed out |

## Verification
The bench builds the block with `STUCK_LIMIT` = 16 instead of the large default, so the dead-driver timeout, the forced clear and the lock release happen within a few dozen cycles. The five configuration inputs are driven with distinct values, which lets each query code be told apart in argument 1. The default capability vectors stay in place, and fully set host vectors expose exactly the 0x73 and 0x03 masks.

// File: rtl/cmd_mailbox_pkg.sv
package cmd_mailbox_pkg;
  localparam int DW = 32;
  localparam int AW = 3;

  typedef enum logic [AW-1:0] {
    ADDR_CMD  = 3'd0,
    ADDR_ARG1 = 3'd1,
    ADDR_ARG2 = 3'd2,
    ADDR_ARG3 = 3'd3,
    ADDR_SIG  = 3'd4,
    ADDR_LOCK = 3'd5
  } regSel_e;

  // control -> datapath strobes
  typedef struct packed {
    logic acceptCmd;  // latch command word and capture arguments
    logic postResp;   // write response word and result arguments
    logic clearReg;   // force command/response word to zero
  } mboxStrobe_t;

  localparam logic [DW-1:0] RSP_OK   = 32'd1;
  localparam logic [DW-1:0] RSP_FAIL = 32'd2;

  localparam logic [DW-1:0] FAILC_SIG     = 32'd1;
  localparam logic [DW-1:0] FAILC_UNSUP   = 32'd2;
  localparam logic [DW-1:0] FAILC_BADCODE = 32'd3;

  localparam logic [15:0] SIG_MAGIC = 16'hCAFE;
endpackage

// File: rtl/cmd_mailbox_ctrl.sv
module cmd_mailbox_ctrl
  import cmd_mailbox_pkg::*;
#(
  parameter int STUCK_LIMIT = 100000
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          regWrEn,
  input  logic          regRdEn,
  input  logic [AW-1:0] regAddr,
  input  logic [DW-1:0] regWrData,
  input  logic          cmdNonClear,
  output mboxStrobe_t   strb,
  output logic          lockFree,
  output logic          stuckError
);
  localparam int CW = $clog2(STUCK_LIMIT + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(STUCK_LIMIT - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_EXEC, ST_WAIT} ctrlState_e;

  ctrlState_e state;
  logic lockHeld;
  logic [CW-1:0] stuckCnt;
  logic cmdHit, clrWr, lockGrab, lockRelease, timeout;

  assign lockGrab    = regRdEn && (regAddr == ADDR_LOCK) && !lockHeld;
  assign lockRelease = regWrEn && (regAddr == ADDR_LOCK);
  assign cmdHit      = regWrEn && (regAddr == ADDR_CMD) && lockHeld;
  assign clrWr       = cmdHit && (regWrData == '0);
  assign timeout     = cmdNonClear && (stuckCnt == CNT_LAST);

  assign strb.clearReg  = clrWr || timeout;
  assign strb.acceptCmd = cmdHit && regWrData[DW-1] && (state == ST_IDLE) && !timeout;
  assign strb.postResp  = (state == ST_EXEC) && !strb.clearReg;
  assign lockFree       = !lockHeld;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else if (strb.clearReg) begin
      state <= ST_IDLE;
    end else if (strb.acceptCmd) begin
      state <= ST_EXEC;
    end else if (state == ST_EXEC) begin
      state <= ST_WAIT;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockHeld <= 1'b0;
    end else if (timeout || lockRelease) begin
      lockHeld <= 1'b0;
    end else if (lockGrab) begin
      lockHeld <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stuckError <= 1'b0;
    end else if (timeout) begin
      stuckError <= 1'b1;
    end else if (lockGrab) begin
      stuckError <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || timeout || !cmdNonClear) begin
      stuckCnt <= '0;
    end else begin
      stuckCnt <= stuckCnt + 1'b1;
    end
  end

  // R3: command writes without the lock leave a clear register clear
  a_r3_no_lock_no_cmd: assert property (@(posedge clk) disable iff (!rstN)
    (!lockHeld && regWrEn && regAddr == ADDR_CMD && !cmdNonClear) |=> !cmdNonClear);

  // R11: a timeout frees the lock, flags the error and clears the register
  a_r11_timeout_recovers: assert property (@(posedge clk) disable iff (!rstN)
    timeout |=> (!lockHeld && stuckError && !cmdNonClear));

  // R2: a lock read by a second party never grants it while held
  a_r2_lock_kept: assert property (@(posedge clk) disable iff (!rstN)
    (lockHeld && !lockRelease && !timeout) |=> lockHeld);
endmodule

// File: rtl/cmd_mailbox_datapath.sv
module cmd_mailbox_datapath
  import cmd_mailbox_pkg::*;
#(
  parameter int            MAX_FUNC = 8,
  parameter logic [DW-1:0] CAP0_VEC = 32'h0000_0073,
  parameter logic [DW-1:0] CAP1_VEC = 32'h0000_0003
) (
  input  logic          clk,
  input  logic          rstN,
  input  mboxStrobe_t   strb,
  input  logic          regWrEn,
  input  logic [AW-1:0] regAddr,
  input  logic [DW-1:0] regWrData,
  input  logic          lockFree,
  input  logic [DW-1:0] cfgMaxRdsRings,
  input  logic [DW-1:0] cfgMaxSdsRings,
  input  logic [DW-1:0] cfgMaxRules,
  input  logic [DW-1:0] cfgMaxRxCtx,
  input  logic [DW-1:0] cfgMaxTxCtx,
  output logic          cmdNonClear,
  output logic [DW-1:0] regRdData
);
  logic [DW-1:0] cmdReg, arg1Reg, arg2Reg, arg3Reg, sigReg;
  logic [DW-1:0] capArg1, capArg2;
  logic [DW-1:0] respCode, respArg1, respArg2;
  logic          respWrArg2, sigOk;
  logic [DW-2:0] code;

  assign code        = cmdReg[DW-2:0];
  assign sigOk       = (sigReg[31:16] == SIG_MAGIC) && (sigReg[7:0] < 8'(MAX_FUNC));
  assign cmdNonClear = (cmdReg != '0);

  // response decode
  always_comb begin
    respCode   = RSP_FAIL;
    respArg1   = FAILC_BADCODE;
    respArg2   = '0;
    respWrArg2 = 1'b0;
    if (!sigOk) begin
      respArg1 = FAILC_SIG;
    end else begin
      case (code)
        31'd1: begin
          respCode   = RSP_OK;
          respArg1   = capArg1 & CAP0_VEC;
          respArg2   = capArg2 & CAP1_VEC;
          respWrArg2 = 1'b1;
        end
        31'd2: begin respCode = RSP_OK; respArg1 = cfgMaxRdsRings; end
        31'd3: begin respCode = RSP_OK; respArg1 = cfgMaxSdsRings; end
        31'd4: begin respCode = RSP_OK; respArg1 = cfgMaxRules;    end
        31'd5: begin respCode = RSP_OK; respArg1 = cfgMaxRxCtx;    end
        31'd6: begin respCode = RSP_OK; respArg1 = cfgMaxTxCtx;    end
        31'd0, 31'd7, 31'd8, 31'd9, 31'd10,
        31'd14, 31'd15, 31'd16: respArg1 = FAILC_UNSUP;
        default: respArg1 = FAILC_BADCODE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdReg <= '0;
    end else if (strb.clearReg) begin
      cmdReg <= '0;
    end else if (strb.postResp) begin
      cmdReg <= respCode;
    end else if (strb.acceptCmd) begin
      cmdReg <= regWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capArg1 <= '0;
      capArg2 <= '0;
    end else if (strb.acceptCmd) begin
      capArg1 <= arg1Reg;
      capArg2 <= arg2Reg;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      arg1Reg <= '0;
      arg2Reg <= '0;
      arg3Reg <= '0;
      sigReg  <= '0;
    end else begin
      if (strb.postResp) begin
        arg1Reg <= respArg1;
      end else if (regWrEn && regAddr == ADDR_ARG1) begin
        arg1Reg <= regWrData;
      end
      if (strb.postResp && respWrArg2) begin
        arg2Reg <= respArg2;
      end else if (regWrEn && regAddr == ADDR_ARG2) begin
        arg2Reg <= regWrData;
      end
      if (regWrEn && regAddr == ADDR_ARG3) begin
        arg3Reg <= regWrData;
      end
      if (regWrEn && regAddr == ADDR_SIG) begin
        sigReg <= regWrData;
      end
    end
  end

  always_comb begin
    case (regAddr)
      ADDR_CMD:  regRdData = cmdReg;
      ADDR_ARG1: regRdData = arg1Reg;
      ADDR_ARG2: regRdData = arg2Reg;
      ADDR_ARG3: regRdData = arg3Reg;
      ADDR_SIG:  regRdData = sigReg;
      ADDR_LOCK: regRdData = {{(DW-1){1'b0}}, lockFree};
      default:   regRdData = '0;
    endcase
  end

  // R5: a posted response is non-zero with bit 31 clear
  a_r5_resp_form: assert property (@(posedge clk) disable iff (!rstN)
    strb.postResp |=> (!cmdReg[DW-1] && cmdReg != '0));

  // R4: a bad signature always yields FAIL with code 1
  a_r4_bad_sig: assert property (@(posedge clk) disable iff (!rstN)
    (strb.postResp && !sigOk) |=> (cmdReg == RSP_FAIL && arg1Reg == FAILC_SIG));

  // R10: a clear strobe empties the register
  a_r10_clear: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearReg |=> (cmdReg == '0));
endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox
  import cmd_mailbox_pkg::*;
#(
  parameter int          STUCK_LIMIT = 100000,
  parameter int          MAX_FUNC    = 8,
  parameter logic [31:0] CAP0_VEC    = 32'h0000_0073,
  parameter logic [31:0] CAP1_VEC    = 32'h0000_0003
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic        regRdEn,
  input  logic [2:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  input  logic [31:0] cfgMaxRdsRings,
  input  logic [31:0] cfgMaxSdsRings,
  input  logic [31:0] cfgMaxRules,
  input  logic [31:0] cfgMaxRxCtx,
  input  logic [31:0] cfgMaxTxCtx,
  output logic        stuckError
);
  mboxStrobe_t strb;
  logic cmdNonClear, lockFree;

  cmd_mailbox_ctrl #(.STUCK_LIMIT(STUCK_LIMIT)) ctrl_i (
    .clk, .rstN, .regWrEn, .regRdEn, .regAddr, .regWrData,
    .cmdNonClear, .strb, .lockFree, .stuckError
  );

  cmd_mailbox_datapath #(
    .MAX_FUNC(MAX_FUNC), .CAP0_VEC(CAP0_VEC), .CAP1_VEC(CAP1_VEC)
  ) dp_i (
    .clk, .rstN, .strb, .regWrEn, .regAddr, .regWrData, .lockFree,
    .cfgMaxRdsRings, .cfgMaxSdsRings, .cfgMaxRules, .cfgMaxRxCtx, .cfgMaxTxCtx,
    .cmdNonClear, .regRdData
  );
endmodule

// File: tb/cmd_mailbox_tb_top.sv
module cmd_mailbox_tb_top;
  localparam int LIMIT = 16;
  localparam logic [2:0] A_CMD = 3'd0, A_ARG1 = 3'd1, A_ARG2 = 3'd2,
                         A_SIG = 3'd4, A_LOCK = 3'd5;
  localparam logic [31:0] SIG_GOOD = 32'hCAFE_0103;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0, regRdEn = 1'b0;
  logic [2:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic stuckError;
  logic [31:0] cfgVal [5];

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [31:0] expQ [$];
  string tagQ [$];

  assign cfgVal[0] = 32'd11;
  assign cfgVal[1] = 32'd22;
  assign cfgVal[2] = 32'd33;
  assign cfgVal[3] = 32'd44;
  assign cfgVal[4] = 32'd55;

  always #2.5 clk = ~clk;  // 5 ns period

  cmd_mailbox #(.STUCK_LIMIT(LIMIT)) dut_i (
    .clk, .rstN, .regWrEn, .regRdEn, .regAddr, .regWrData, .regRdData,
    .cfgMaxRdsRings(cfgVal[0]), .cfgMaxSdsRings(cfgVal[1]), .cfgMaxRules(cfgVal[2]),
    .cfgMaxRxCtx(cfgVal[3]), .cfgMaxTxCtx(cfgVal[4]), .stuckError
  );

  // scoreboard monitor: compares every read against the queued expectation
  always @(negedge clk) begin
    if (regRdEn && expQ.size() > 0) begin
      logic [31:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      total++;
      if (regRdData !== e) begin
        bad++;
        $display("FAIL %s: got %h expected %h", t, regRdData, e);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk); #1;
    regWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [2:0] a, input logic [31:0] e, input string t);
    expQ.push_back(e);
    tagQ.push_back(t);
    regRdEn = 1'b1; regAddr = a;
    @(posedge clk); #1;
    regRdEn = 1'b0;
  endtask

  task automatic checkStuck(input logic e, input string t);
    total++;
    if (stuckError !== e) begin
      bad++;
      $display("FAIL %s: stuckError got %b expected %b", t, stuckError, e);
    end
  endtask

  task automatic runCmd(input logic [30:0] code, input logic [31:0] rsp,
                        input logic [31:0] a1, input string t);
    busWrite(A_CMD, {1'b1, code});
    idle(1);
    busRead(A_CMD, rsp, t);
    busRead(A_ARG1, a1, t);
    busWrite(A_CMD, 32'd0);
    busRead(A_CMD, 32'd0, {t, " cleared (R10)"});
  endtask

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);
    // R1 reset state
    busRead(A_CMD, 32'd0, "R1 cmd");
    busRead(A_ARG1, 32'd0, "R1 arg1");
    busRead(A_SIG, 32'd0, "R1 sig");
    checkStuck(1'b0, "R1 stuck");
    // R3 command without lock
    busWrite(A_CMD, 32'h8000_0002);
    idle(2);
    busRead(A_CMD, 32'd0, "R3 ignored");
    // R2 lock grab then denied
    busRead(A_LOCK, 32'd1, "R2 grab");
    busRead(A_LOCK, 32'd0, "R2 held");
    // R4 signature readback
    busWrite(A_SIG, SIG_GOOD);
    busRead(A_SIG, SIG_GOOD, "R4 sig rw");
    // R6 queries, R5 response form
    for (int i = 0; i < 5; i++) begin
      runCmd(31'(i + 2), 32'd1, cfgVal[i], "R6 R5 query");
    end
    // R7 capability exchange, R8 late arg2 write overridden
    busWrite(A_ARG1, 32'hFFFF_FFFF);
    busWrite(A_ARG2, 32'hFFFF_FFFF);
    busWrite(A_CMD, 32'h8000_0001);
    busWrite(A_ARG2, 32'd0);
    busRead(A_CMD, 32'd1, "R7 ok");
    busRead(A_ARG1, 32'h73, "R7 cap0");
    busRead(A_ARG2, 32'h03, "R8 cap1 from captured arg");
    busWrite(A_CMD, 32'd0);
    busWrite(A_ARG1, 32'h21);
    busWrite(A_ARG2, 32'h2);
    runCmd(31'd1, 32'd1, 32'h21, "R7 partial cap0");
    busRead(A_ARG2, 32'h2, "R7 partial cap1");
    // R10 writes while a response is pending
    busWrite(A_CMD, 32'h8000_0002);
    idle(1);
    busWrite(A_CMD, 32'h8000_0003);
    busRead(A_CMD, 32'd1, "R10 second cmd ignored");
    busWrite(A_CMD, 32'h0000_0005);
    busRead(A_CMD, 32'd1, "R10 non-command ignored");
    busRead(A_ARG1, cfgVal[0], "R10 arg1 kept");
    busWrite(A_CMD, 32'd0);
    // R9 unsupported and invalid codes
    runCmd(31'd7, 32'd2, 32'd2, "R9 code7");
    runCmd(31'd16, 32'd2, 32'd2, "R9 code16");
    runCmd(31'd0, 32'd2, 32'd2, "R9 code0");
    runCmd(31'd12, 32'd2, 32'd3, "R9 code12");
    runCmd(31'd17, 32'd2, 32'd3, "R9 code17");
    runCmd(31'h7FFF_FFFF, 32'd2, 32'd3, "R9 code max");
    // R4 signature validation
    busWrite(A_SIG, 32'hCAFE_0108);
    runCmd(31'd2, 32'd2, 32'd1, "R4 fn8");
    busWrite(A_SIG, 32'hCAFF_0100);
    runCmd(31'd2, 32'd2, 32'd1, "R4 magic");
    busWrite(A_SIG, 32'hCAFE_FF07);
    runCmd(31'd3, 32'd1, cfgVal[1], "R4 fn7 ok");
    // R2 release and regrab
    busWrite(A_LOCK, 32'd0);
    busRead(A_LOCK, 32'd1, "R2 regrab");
    // R11 stuck detection
    busWrite(A_CMD, 32'h8000_0004);
    idle(LIMIT - 4);
    checkStuck(1'b0, "R11 not yet");
    busRead(A_CMD, 32'd1, "R11 still pending");
    idle(8);
    checkStuck(1'b1, "R11 flagged");
    busRead(A_CMD, 32'd0, "R11 forced clear");
    busRead(A_LOCK, 32'd1, "R11 lock freed");
    checkStuck(1'b0, "R11 cleared by grab");
    idle(2);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule